// File: doc/BRIEF.md
# Key-Locked Expiry-Counting Watchdog

This block pairs a down-counting tick timer with a watchdog that counts how many times that timer runs out. The timer is loaded through its own small register bus with a reload count, a run bit and an auto-reload bit. It counts down on a prescaled tick strobe and latches an expiry flag that software clears by writing a one to it. The watchdog counts the timer's expiries after software starts it. It raises an interrupt on the first expiry. On the fourth it emits one-cycle reset pulses toward the system and toward the clock/reset controller. Each of these three outputs has its own enable.

A start command restarts the expiry count, so software keeps the watchdog quiet by issuing start periodically. A stop command takes effect only if the last write to the key register carried the 16-bit key 0xC45A. The next command write uses up that key. With 125000 ticks per second, a reload count of 312500 gives 2.5 s per expiry, which is 10 s to the reset.

Top module: `wdt_top`

## Requirements
- R1: After reset, irq_o, sys_rst_o and ctl_rst_o are low, and both timer registers and both watchdog registers (offsets 0x0 and 0x4) read zero.
- R2: Timer offset 0x0 holds bit 31 run, bit 30 auto-reload and bits [28:0] reload count, and reads back as written. Writing it also loads the current count. Timer offset 0x4 reads bit 30 expiry flag and bits [28:0] current count. The count does not move while the run bit is clear.
- R3: With run set and reload N≥1, each tick lowers the count by one. The N-th tick after the load is an expiry and sets the flag.
- R4: On expiry with auto-reload set, the count is reloaded to N and expiries repeat every N ticks. Without auto-reload, the run bit clears, the count stays 0 and later ticks cause no expiry.
- R5: Writing 1 to bit 30 at timer offset 0x4 clears the expiry flag. Writing 0 there leaves it set.
- R6: Writing bit 0 at watchdog offset 0x8 starts the watchdog with its expiry count at zero. Expiries are counted only while it is running.
- R7: If config bit 12 is set, irq_o rises on the first expiry after a start. It stays high until the next start or accepted stop. It never rises if bit 12 is clear.
- R8: On the fourth expiry after a start, sys_rst_o pulses for exactly one cycle if config bit 14 is set, and ctl_rst_o does the same if bit 15 is set. The watchdog then stops, leaving its count at 4.
- R9: Writing bit 1 at offset 0x8 stops the watchdog and clears its count and irq_o only if the most recent write to offset 0xC was exactly 0x0000C45A. Otherwise it is ignored. Writing any other value to 0xC disarms the key, and every write to 0x8 consumes it.
- R10: A start while running (a kick) resets the count to zero and drops irq_o, so the reset needs four fresh expiries.
- R11: Watchdog offset 0x0 reads back only bits [3:0] source, 12, 14 and 15. Offset 0x4 reads bit 0 running, bits [6:4] expiry count, bit 8 key armed and bit 12 interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaled tick strobe, one cycle per tick |
| tmr_wr_en | input | 1 | Timer register write strobe |
| tmr_addr | input | 4 | Timer register byte offset |
| tmr_wdata | input | 32 | Timer write data |
| tmr_rdata | output | 32 | Timer read data (combinational) |
| wdg_wr_en | input | 1 | Watchdog register write strobe |
| wdg_addr | input | 4 | Watchdog register byte offset |
| wdg_wdata | input | 32 | Watchdog write data |
| wdg_rdata | output | 32 | Watchdog read data (combinational) |
| irq_o | output | 1 | Watchdog interrupt, level |
| sys_rst_o | output | 1 | System reset request, one-cycle pulse |
| ctl_rst_o | output | 1 | Clock/reset controller reset request, one-cycle pulse |

## Verification
The hardest state to reach is the fourth expiry under every mix of the three output enables and several reload lengths. Each output must be low on every earlier tick and high for exactly one cycle after the firing tick. The bench sweeps all eight enable combinations against reloads one to four and predicts every output on every tick from the tick and expiry indices. The key sequencing is driven on its own: the key write is followed by an unrelated config write, by a wrong key, or by a start that consumes it, so that a stop lands both armed and disarmed while the watchdog holds a partial count.

// File: rtl/wdt_pkg.sv
// Shared register offsets, bit positions and the config record for the
// watchdog and its tick timer. Assumes 4-bit byte offsets on both buses.
package wdt_pkg;
    localparam int unsigned TMR_OFS_VALUE = 0;
    localparam int unsigned TMR_OFS_STAT  = 4;
    localparam int unsigned WDG_OFS_CFG   = 0;
    localparam int unsigned WDG_OFS_STAT  = 4;
    localparam int unsigned WDG_OFS_CMD   = 8;
    localparam int unsigned WDG_OFS_KEY   = 12;

    localparam int unsigned TMR_RUN_B   = 31;
    localparam int unsigned TMR_AUTO_B  = 30;
    localparam int unsigned TMR_FLAG_B  = 30;
    localparam int unsigned CFG_IRQ_B   = 12;
    localparam int unsigned CFG_SRST_B  = 14;
    localparam int unsigned CFG_CRST_B  = 15;
    localparam int unsigned CMD_GO_B    = 0;
    localparam int unsigned CMD_STOP_B  = 1;
    localparam int unsigned ST_RUN_B    = 0;
    localparam int unsigned ST_CNT_LSB  = 4;
    localparam int unsigned ST_ARMED_B  = 8;
    localparam int unsigned ST_IRQ_B    = 12;

    typedef struct packed {
        logic [3:0] src;
        logic       irq_en;
        logic       srst_en;
        logic       crst_en;
    } wdg_cfg_t;
endpackage

// File: rtl/tmr_core.sv
// Down-counting tick timer with reload, auto-reload and sticky expiry flag.
// Assumes CNT_W <= 29 so the count never overlaps the control bits.
// expire_o is combinational: high in the cycle whose tick ends the period.
module tmr_core
    import wdt_pkg::*;
#(
    parameter int CNT_W = 29,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output logic          expire_o
);
    logic             run_q;
    logic             auto_q;
    logic             flag_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;
    logic             wr_value;
    logic             wr_stat;
    logic             unused_bits;

    assign wr_value    = wr_en && (addr == AW'(TMR_OFS_VALUE));
    assign wr_stat     = wr_en && (addr == AW'(TMR_OFS_STAT));
    assign expire_o    = tick && run_q && (count_q < CNT_W'(2));
    assign unused_bits = ^wdata;

    // Load on write, reload or stop on expiry, otherwise count ticks down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            auto_q   <= 1'b0;
            reload_q <= '0;
            count_q  <= '0;
        end else if (wr_value) begin
            run_q    <= wdata[TMR_RUN_B];
            auto_q   <= wdata[TMR_AUTO_B];
            reload_q <= wdata[CNT_W-1:0];
            count_q  <= wdata[CNT_W-1:0];
        end else if (expire_o) begin
            if (auto_q) begin
                count_q <= reload_q;
            end else begin
                run_q   <= 1'b0;
                count_q <= '0;
            end
        end else if (tick && run_q) begin
            count_q <= count_q - CNT_W'(1);
        end
    end

    // Sticky expiry flag, cleared by writing one; a new expiry wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (expire_o) begin
            flag_q <= 1'b1;
        end else if (wr_stat && wdata[TMR_FLAG_B]) begin
            flag_q <= 1'b0;
        end
    end

    // Register read mux.
    always_comb begin
        rdata = '0;
        if (addr == AW'(TMR_OFS_VALUE)) begin
            rdata[TMR_RUN_B]   = run_q;
            rdata[TMR_AUTO_B]  = auto_q;
            rdata[CNT_W-1:0]   = reload_q;
        end else if (addr == AW'(TMR_OFS_STAT)) begin
            rdata[TMR_FLAG_B]  = flag_q;
            rdata[CNT_W-1:0]   = count_q;
        end
    end
endmodule

// File: rtl/wdg_keyguard.sv
// Holds the armed state for the stop command. A key-register write arms it
// only on an exact match; any command write consumes it.
module wdg_keyguard #(
    parameter logic [15:0] KEY = 16'hC45A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [31:0] key_data,
    input  logic        cmd_wr,
    output logic        armed_o
);
    // Arm on matching key, disarm on mismatch or on any command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_o <= 1'b0;
        end else if (key_wr) begin
            armed_o <= (key_data == {16'h0000, KEY});
        end else if (cmd_wr) begin
            armed_o <= 1'b0;
        end
    end
endmodule

// File: rtl/wdg_ctrl.sv
// Watchdog core: config register, start/stop commands, expiry counter,
// interrupt level and one-cycle reset pulses on the FIRE_AT-th expiry.
// Assumes expire_i is a single-cycle strobe from the tick timer.
module wdg_ctrl
    import wdt_pkg::*;
#(
    parameter int FIRE_AT = 4,
    parameter int AW      = 4,
    localparam int CW     = $clog2(FIRE_AT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    input  logic          expire_i,
    input  logic          armed_i,
    output logic          cmd_wr_o,
    output logic          key_wr_o,
    output logic [31:0]   rdata,
    output logic          running_o,
    output logic [CW-1:0] cnt_o,
    output logic          irq_o,
    output logic          sys_rst_o,
    output logic          ctl_rst_o
);
    wdg_cfg_t      cfg_q;
    logic          running_q;
    logic [CW-1:0] cnt_q;
    logic          irq_q;
    logic          srst_q;
    logic          crst_q;
    logic          cfg_wr;
    logic          stop_ok;
    logic          go;
    logic          fire;
    logic          unused_bits;

    assign cfg_wr      = wr_en && (addr == AW'(WDG_OFS_CFG));
    assign cmd_wr_o    = wr_en && (addr == AW'(WDG_OFS_CMD));
    assign key_wr_o    = wr_en && (addr == AW'(WDG_OFS_KEY));
    assign stop_ok     = cmd_wr_o && wdata[CMD_STOP_B] && armed_i;
    assign go          = cmd_wr_o && wdata[CMD_GO_B] && !stop_ok;
    assign fire        = running_q && expire_i && !stop_ok && !go
                         && (cnt_q == CW'(FIRE_AT - 1));
    assign unused_bits = ^wdata;

    // Config register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q.src     <= wdata[3:0];
            cfg_q.irq_en  <= wdata[CFG_IRQ_B];
            cfg_q.srst_en <= wdata[CFG_SRST_B];
            cfg_q.crst_en <= wdata[CFG_CRST_B];
        end
    end

    // Run state, expiry count and interrupt; stop beats start beats expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
            irq_q     <= 1'b0;
        end else if (stop_ok) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
            irq_q     <= 1'b0;
        end else if (go) begin
            running_q <= 1'b1;
            cnt_q     <= '0;
            irq_q     <= 1'b0;
        end else if (running_q && expire_i) begin
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == '0 && cfg_q.irq_en) begin
                irq_q <= 1'b1;
            end
            if (fire) begin
                running_q <= 1'b0;
            end
        end
    end

    // One-cycle reset pulses on the firing expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_q <= 1'b0;
            crst_q <= 1'b0;
        end else begin
            srst_q <= fire && cfg_q.srst_en;
            crst_q <= fire && cfg_q.crst_en;
        end
    end

    // Register read mux.
    always_comb begin
        rdata = '0;
        if (addr == AW'(WDG_OFS_CFG)) begin
            rdata[3:0]        = cfg_q.src;
            rdata[CFG_IRQ_B]  = cfg_q.irq_en;
            rdata[CFG_SRST_B] = cfg_q.srst_en;
            rdata[CFG_CRST_B] = cfg_q.crst_en;
        end else if (addr == AW'(WDG_OFS_STAT)) begin
            rdata[ST_RUN_B]          = running_q;
            rdata[ST_CNT_LSB +: CW]  = cnt_q;
            rdata[ST_ARMED_B]        = armed_i;
            rdata[ST_IRQ_B]          = irq_q;
        end
    end

    assign running_o = running_q;
    assign cnt_o     = cnt_q;
    assign irq_o     = irq_q;
    assign sys_rst_o = srst_q;
    assign ctl_rst_o = crst_q;
endmodule

// File: rtl/wdt_top.sv
// Top level: tick timer feeding the expiry-counting watchdog and its key
// guard. Assumes tick is already prescaled to one strobe per timer tick.
module wdt_top #(
    parameter int          CNT_W   = 29,
    parameter int          FIRE_AT = 4,
    parameter logic [15:0] KEY     = 16'hC45A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        tmr_wr_en,
    input  logic [3:0]  tmr_addr,
    input  logic [31:0] tmr_wdata,
    output logic [31:0] tmr_rdata,
    input  logic        wdg_wr_en,
    input  logic [3:0]  wdg_addr,
    input  logic [31:0] wdg_wdata,
    output logic [31:0] wdg_rdata,
    output logic        irq_o,
    output logic        sys_rst_o,
    output logic        ctl_rst_o
);
    localparam int CW = $clog2(FIRE_AT + 1);

    logic          tmr_expire;
    logic          key_armed;
    logic          cmd_wr;
    logic          key_wr;
    logic          wdg_running;
    logic [CW-1:0] wdg_cnt;

    tmr_core #(.CNT_W(CNT_W), .AW(4)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wr_en    (tmr_wr_en),
        .addr     (tmr_addr),
        .wdata    (tmr_wdata),
        .rdata    (tmr_rdata),
        .expire_o (tmr_expire)
    );

    wdg_keyguard #(.KEY(KEY)) key_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_data (wdg_wdata),
        .cmd_wr   (cmd_wr),
        .armed_o  (key_armed)
    );

    wdg_ctrl #(.FIRE_AT(FIRE_AT), .AW(4)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wdg_wr_en),
        .addr      (wdg_addr),
        .wdata     (wdg_wdata),
        .expire_i  (tmr_expire),
        .armed_i   (key_armed),
        .cmd_wr_o  (cmd_wr),
        .key_wr_o  (key_wr),
        .rdata     (wdg_rdata),
        .running_o (wdg_running),
        .cnt_o     (wdg_cnt),
        .irq_o     (irq_o),
        .sys_rst_o (sys_rst_o),
        .ctl_rst_o (ctl_rst_o)
    );
endmodule

// File: rtl/wdt_checker.sv
// Temporal checks on the watchdog, attached to wdt_top by the bind below.
// Observes the timer strobe, key state and command decode between blocks.
module wdt_checker #(
    parameter int FIRE_AT = 4,
    localparam int CW     = $clog2(FIRE_AT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          cmd_wr,
    input logic          cmd_go,
    input logic          cmd_stop,
    input logic          exp_pulse,
    input logic [CW-1:0] exp_cnt,
    input logic          running,
    input logic          armed,
    input logic          irq_o,
    input logic          sys_rst_o,
    input logic          ctl_rst_o
);
    // R3: an expiry only happens on a tick.
    a_r3_expiry_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        exp_pulse |-> tick);

    // R8: reset pulses last one cycle.
    a_r8_sys_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |=> !sys_rst_o);
    a_r8_ctl_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst_o |=> !ctl_rst_o);

    // R8: a reset pulse follows the final counted expiry and stops the unit.
    a_r8_sys_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> ($past(exp_pulse) && $past(running)
                       && ($past(exp_cnt) == CW'(FIRE_AT - 1)) && !running));
    a_r8_ctl_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst_o |-> ($past(exp_pulse) && ($past(exp_cnt) == CW'(FIRE_AT - 1))));

    // R8: the count never passes the firing expiry.
    a_r8_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        exp_cnt <= CW'(FIRE_AT));

    // R7: the interrupt rises only on the first counted expiry.
    a_r7_irq_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(exp_pulse) && ($past(exp_cnt) == '0)));

    // R9: a stop without an armed key leaves a running watchdog running.
    a_r9_locked_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_stop && !cmd_go && !armed && running
         && !(exp_pulse && exp_cnt == CW'(FIRE_AT - 1))) |=> running);

    // R10: a start (not overridden by an armed stop) restarts from zero.
    a_r10_kick: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_go && !(cmd_stop && armed)) |=>
            (running && exp_cnt == '0 && !irq_o));
endmodule

bind wdt_top wdt_checker #(.FIRE_AT(FIRE_AT)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cmd_wr    (cmd_wr),
    .cmd_go    (wdg_wdata[0]),
    .cmd_stop  (wdg_wdata[1]),
    .exp_pulse (tmr_expire),
    .exp_cnt   (wdg_cnt),
    .running   (wdg_running),
    .armed     (key_armed),
    .irq_o     (irq_o),
    .sys_rst_o (sys_rst_o),
    .ctl_rst_o (ctl_rst_o)
);

// File: tb/wdt_top_tb_top.sv
`timescale 1ns/1ps
module wdt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        t_wr = 1'b0;
    logic [3:0]  t_addr = '0;
    logic [31:0] t_wdata = '0;
    logic [31:0] t_rdata;
    logic        w_wr = 1'b0;
    logic [3:0]  w_addr = '0;
    logic [31:0] w_wdata = '0;
    logic [31:0] w_rdata;
    logic        irq, srst, crst;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wdt_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .tmr_wr_en(t_wr), .tmr_addr(t_addr), .tmr_wdata(t_wdata), .tmr_rdata(t_rdata),
        .wdg_wr_en(w_wr), .wdg_addr(w_addr), .wdg_wdata(w_wdata), .wdg_rdata(w_rdata),
        .irq_o(irq), .sys_rst_o(srst), .ctl_rst_o(crst)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic twr(input logic [3:0] a, input logic [31:0] d);
        t_addr = a; t_wdata = d; t_wr = 1'b1;
        @(negedge clk);
        t_wr = 1'b0;
    endtask

    task automatic wwr(input logic [3:0] a, input logic [31:0] d);
        w_addr = a; w_wdata = d; w_wr = 1'b1;
        @(negedge clk);
        w_wr = 1'b0;
    endtask

    task automatic trd(input logic [3:0] a, output logic [31:0] d);
        t_addr = a; #1; d = t_rdata;
    endtask

    task automatic wrd(input logic [3:0] a, output logic [31:0] d);
        w_addr = a; #1; d = w_rdata;
    endtask

    task automatic tick1();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired act=hung exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 srst", {31'd0, srst}, 32'd0);
        chk("R1 crst", {31'd0, crst}, 32'd0);
        trd(4'h0, rd); chk("R1 tmr value", rd, 32'd0);
        trd(4'h4, rd); chk("R1 tmr stat", rd, 32'd0);
        wrd(4'h0, rd); chk("R1 wdg cfg", rd, 32'd0);
        wrd(4'h4, rd); chk("R1 wdg stat", rd, 32'd0);

        // R2: layout and readback, count frozen while not running
        twr(4'h0, 32'h4000_1234);
        trd(4'h0, rd); chk("R2 value readback", rd, 32'h4000_1234);
        trd(4'h4, rd); chk("R2 count loaded", rd, 32'h0000_1234);
        tick1();
        trd(4'h4, rd); chk("R2 count frozen when stopped", rd, 32'h0000_1234);

        // R11: config readback masks unused bits
        wwr(4'h0, 32'hFFFF_FFFF);
        wrd(4'h0, rd); chk("R11 cfg readback", rd, 32'h0000_D00F);

        // R3 R7 R8 sweep: all enable combinations x reloads 1..4
        for (int cfg_i = 0; cfg_i < 8; cfg_i++) begin
            for (int n = 1; n <= 4; n++) begin
                bit ien, sen, cen;
                ien = cfg_i[0]; sen = cfg_i[1]; cen = cfg_i[2];
                twr(4'h0, 32'hC000_0000 | 32'(n));
                twr(4'h4, 32'h4000_0000);
                wwr(4'h0, (32'(ien) << 12) | (32'(sen) << 14) | (32'(cen) << 15));
                wwr(4'h8, 32'h1);
                for (int e = 1; e <= 4; e++) begin
                    for (int k = 1; k <= n; k++) begin
                        bit now;
                        tick1();
                        now = (k == n);
                        chk("R7 irq level", {31'd0, irq},
                            {31'd0, ien && (e > 1 || now)});
                        chk("R8 sys_rst pulse", {31'd0, srst},
                            {31'd0, sen && e == 4 && now});
                        chk("R8 ctl_rst pulse", {31'd0, crst},
                            {31'd0, cen && e == 4 && now});
                        if (now) begin
                            trd(4'h4, rd);
                            chk("R4 periodic reload + R3 flag", rd, 32'h4000_0000 | 32'(n));
                        end else begin
                            trd(4'h4, rd);
                            chk("R3 countdown", rd & 32'h1FFF_FFFF, 32'(n - k));
                        end
                    end
                end
                @(negedge clk);
                chk("R8 sys_rst one cycle", {31'd0, srst}, 32'd0);
                chk("R8 ctl_rst one cycle", {31'd0, crst}, 32'd0);
                wrd(4'h4, rd);
                chk("R8 stopped at count 4", rd, 32'h40 | (32'(ien) << 12));
                twr(4'h0, 32'h0);
            end
        end

        // R9 accepted stop clears; R6 expiries ignored while stopped
        twr(4'h0, 32'hC000_0002);
        wwr(4'hC, 32'h0000_C45A);
        wwr(4'h8, 32'h2);
        wrd(4'h4, rd); chk("R9 accepted stop clears", rd, 32'h0);
        chk("R9 irq cleared", {31'd0, irq}, 32'd0);
        repeat (4) tick1();
        wrd(4'h4, rd); chk("R6 no count while stopped", rd, 32'h0);

        // R9 locked stop sequences
        twr(4'h0, 32'hC000_0002);
        wwr(4'h0, 32'h0000_D000);
        wwr(4'h8, 32'h1);
        wrd(4'h4, rd); chk("R6 start", rd, 32'h1);
        tick1(); tick1();
        wrd(4'h4, rd); chk("R6 one expiry counted", rd, 32'h1011);
        wwr(4'h8, 32'h2);
        wrd(4'h4, rd); chk("R9 stop without key ignored", rd, 32'h1011);
        wwr(4'hC, 32'h0000_C45B);
        wrd(4'h4, rd); chk("R9 wrong key not armed", rd, 32'h1011);
        wwr(4'h8, 32'h2);
        wrd(4'h4, rd); chk("R9 stop after wrong key ignored", rd, 32'h1011);
        wwr(4'hC, 32'h0000_C45A);
        wrd(4'h4, rd); chk("R9 key armed", rd, 32'h1111);
        wwr(4'h0, 32'h0000_D000);
        wrd(4'h4, rd); chk("R9 armed survives cfg write", rd, 32'h1111);
        wwr(4'h8, 32'h2);
        wrd(4'h4, rd); chk("R9 armed stop accepted", rd, 32'h0);
        wwr(4'hC, 32'h0000_C45A);
        wwr(4'h8, 32'h1);
        wrd(4'h4, rd); chk("R9 start consumes key", rd, 32'h1);
        wwr(4'h8, 32'h2);
        wrd(4'h4, rd); chk("R9 stop after consumed key ignored", rd, 32'h1);

        // R10 kick: three expiries, kick, then four fresh ones needed
        repeat (6) tick1();
        wrd(4'h4, rd); chk("R10 three expiries", rd, 32'h1031);
        wwr(4'h8, 32'h1);
        wrd(4'h4, rd); chk("R10 kick zeroes count", rd, 32'h1);
        chk("R10 kick drops irq", {31'd0, irq}, 32'd0);
        for (int k = 0; k < 6; k++) begin
            tick1();
            chk("R10 no reset before fourth", {31'd0, srst}, 32'd0);
        end
        tick1(); tick1();
        chk("R10 reset on fourth after kick", {31'd0, srst}, 32'd1);
        chk("R10 ctl reset on fourth after kick", {31'd0, crst}, 32'd1);

        // R4 one-shot, R5 flag clear
        twr(4'h0, 32'h8000_0003);
        twr(4'h4, 32'h4000_0000);
        trd(4'h4, rd); chk("R5 flag cleared by one", rd, 32'h3);
        tick1();
        trd(4'h4, rd); chk("R3 decrement", rd, 32'h2);
        tick1(); tick1();
        trd(4'h4, rd); chk("R4 one-shot expiry", rd, 32'h4000_0000);
        trd(4'h0, rd); chk("R4 one-shot clears run", rd, 32'h3);
        repeat (3) tick1();
        trd(4'h4, rd); chk("R4 one-shot stays stopped", rd, 32'h4000_0000);
        twr(4'h4, 32'h0);
        trd(4'h4, rd); chk("R5 write zero keeps flag", rd, 32'h4000_0000);
        twr(4'h4, 32'h4000_0000);
        trd(4'h4, rd); chk("R5 write one clears flag", rd, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule